// File: doc/BRIEF.md
# Multi-Latency Issue Hazard Controller

This block sits at the in-order issue point of a pipeline whose execution units have different latencies. Each cycle the decode stage presents one instruction on a valid/ready input: its execution unit class, an optional destination register and up to two optional source registers. The block either passes the instruction to the execute stage on a valid/ready output or holds it in decode. A held instruction blocks every younger instruction behind it, so program order is kept.

Issue is refused on three kinds of conflict. The first is a source register whose producer's result is not yet usable (read-after-write). The second is a destination register that an older, still-running instruction will write no earlier than the new one (write-after-write). The third is a structural conflict: either the single non-pipelined divider is still busy, or the one writeback port is already claimed in the cycle the new instruction would use it. Full forwarding is assumed, so a consumer waits exactly the producer's latency in cycles. Write-after-read cannot arise, because operands are read in order at issue.

Back-pressure: `in_ready` is high only when the execute stage is ready and no hazard exists. `out_valid` is high only when an instruction is presented and no hazard exists. An instruction issues in a cycle where both `in_valid` and `in_ready` are high, and the execute stage must take it in that cycle.

Top module: `issue_hazard_ctrl`

## Requirements
- R1: `out_valid` = `in_valid` and no hazard. `in_ready` = `out_ready` and no hazard. An instruction issues only when `in_valid`, `out_ready` and no hazard are all true together. `out_class`, `out_dst` and `out_dst_en` copy the presented instruction. While `out_ready` is low, nothing issues.
- R2: The unit class code sets the latency L. Code 0 is the integer ALU (L=0). Code 1 is a load (L=1). Code 2 is an FP add (L=3). Code 3 is a multiply (L=6). Code 4 is a divide (L=24). Codes 5 to 7 behave as the integer ALU.
- R3: If a producer with latency L issues in cycle t, a consumer of its destination issues no earlier than cycle t+1+L. Presented in cycle t+1, the consumer therefore waits exactly L cycles.
- R4: Both source fields are checked, each only when its enable is set. A pending write to a register delays no reader of any other register.
- R5: An instruction whose destination equals an older pending destination issues only once its own latency is at least the older instruction's remaining cycles. For a multiply followed at once by an ALU op to the same register, this is a 6-cycle wait. For a load in the same position it is a 5-cycle wait.
- R6: A second divide issues no earlier than 25 cycles after the previous divide issued. Other classes issue freely while the divider is busy.
- R7: Only one result may reach writeback in any cycle. An instruction with a destination is held if its completion cycle is already reserved, so an ALU op with a destination right after a load waits 1 cycle. Instructions without a destination neither check nor reserve a slot.
- R8: Reset clears all register counters, the divider busy state and the writeback reservations. After reset, `in_ready` follows `out_ready`, even if reset struck with operations in flight.
- R9: `stall` is high exactly when an instruction is presented and a hazard holds it, whatever the level of `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode presents an instruction |
| in_ready | output | 1 | Instruction is accepted this cycle |
| in_class | input | 3 | Execution unit class code |
| in_dst | input | 5 | Destination register |
| in_dst_en | input | 1 | Instruction writes a register |
| in_src0 | input | 5 | First source register |
| in_src0_en | input | 1 | First source is read |
| in_src1 | input | 5 | Second source register |
| in_src1_en | input | 1 | Second source is read |
| out_valid | output | 1 | Issued instruction to execute stage |
| out_ready | input | 1 | Execute stage can take an instruction |
| out_class | output | 3 | Class of the issued instruction |
| out_dst | output | 5 | Destination of the issued instruction |
| out_dst_en | output | 1 | Issued instruction writes a register |
| stall | output | 1 | Presented instruction is held by a hazard |

## Verification
A wrong internal state shows up at the ports as a wrong wait count. A register counter loaded with the wrong latency, or one that decrements wrongly, changes the number of cycles before a dependent instruction issues. A wrong divider count does the same for the next divide, and a misplaced writeback reservation either adds an extra cycle of stall or removes a needed one. Each of these errors shows on the very next instruction that touches the affected register, unit or slot. The bench therefore measures exact wait counts, presenting each consumer in the cycle right after its producer issued. It also checks that state left over after a reset mid-flight delays nothing.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU  = 3'd0,
    CL_LOAD = 3'd1,
    CL_FADD = 3'd2,
    CL_MUL  = 3'd3,
    CL_DIV  = 3'd4
  } unit_cls_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/reg_ready_table.sv
// Per-register countdown of cycles until a pending result is usable.
module reg_ready_table #(
  parameter int NREG    = 32,
  parameter int MAX_LAT = 24,
  localparam int RW = $clog2(NREG),
  localparam int LW = $clog2(MAX_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_reg,
  input  logic [LW-1:0] wr_lat,
  input  logic [RW-1:0] rd_a,
  input  logic [RW-1:0] rd_b,
  input  logic [RW-1:0] rd_d,
  output logic          pend_a,
  output logic          pend_b,
  output logic [LW-1:0] left_d
);
  logic [LW-1:0] left_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        left_q[r] <= '0;
      else if (wr_en && wr_reg == RW'(r))
        left_q[r] <= wr_lat;
      else if (left_q[r] != '0)
        left_q[r] <= left_q[r] - 1'b1;
    end

    // R3
    left_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      left_q[r] <= LW'(MAX_LAT));
  end

  assign pend_a = (left_q[rd_a] != '0);
  assign pend_b = (left_q[rd_b] != '0);
  assign left_d = left_q[rd_d];
endmodule

// File: rtl/wb_slot_map.sv
// Reservation shift register for the single writeback port.
module wb_slot_map #(
  parameter int MAX_LAT = 24,
  localparam int LW    = $clog2(MAX_LAT + 1),
  localparam int RES_W = MAX_LAT + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim,
  input  logic [LW-1:0] lat,
  output logic          taken
);
  logic [RES_W-1:0] slot_q;
  logic [RES_W-1:0] claim_mask;

  assign taken      = slot_q[lat];
  assign claim_mask = claim ? ((RES_W'(1) << lat) >> 1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= (slot_q >> 1) | claim_mask;
  end

  // R7
  slot_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim && lat != '0 |=> slot_q[$past(lat) - 1'b1]);
endmodule

// File: rtl/unit_busy_timer.sv
// Busy window for a non-pipelined unit with initiation interval II.
module unit_busy_timer #(
  parameter int II = 25,
  localparam int CW = (II > 2) ? $clog2(II) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            left_q <= '0;
    else if (start)        left_q <= CW'(II - 1);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

  // R6
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && II > 1 |=> busy);
endmodule

// File: rtl/issue_hazard_ctrl.sv
module issue_hazard_ctrl
  import issue_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int LAT_ALU  = 0,
  parameter int LAT_LOAD = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_MUL  = 6,
  parameter int LAT_DIV  = 24,
  parameter int DIV_II   = 25,
  localparam int RW      = $clog2(NREG),
  localparam int MAX_LAT = max2(max2(max2(LAT_ALU, LAT_LOAD), max2(LAT_FADD, LAT_MUL)), LAT_DIV),
  localparam int LW      = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CLS_W-1:0] in_class,
  input  logic [RW-1:0]    in_dst,
  input  logic             in_dst_en,
  input  logic [RW-1:0]    in_src0,
  input  logic             in_src0_en,
  input  logic [RW-1:0]    in_src1,
  input  logic             in_src1_en,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CLS_W-1:0] out_class,
  output logic [RW-1:0]    out_dst,
  output logic             out_dst_en,
  output logic             stall
);
  logic [LW-1:0] lat;
  logic          is_div;
  logic          pend_a, pend_b;
  logic [LW-1:0] dst_left;
  logic          slot_taken, div_busy;
  logic          raw_hz, waw_hz, wb_hz, div_hz, hazard, fire;

  always_comb begin
    is_div = 1'b0;
    case (in_class)
      CL_LOAD: lat = LW'(LAT_LOAD);
      CL_FADD: lat = LW'(LAT_FADD);
      CL_MUL:  lat = LW'(LAT_MUL);
      CL_DIV:  begin lat = LW'(LAT_DIV); is_div = 1'b1; end
      default: lat = LW'(LAT_ALU);
    endcase
  end

  reg_ready_table #(.NREG(NREG), .MAX_LAT(MAX_LAT)) u_ready (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fire && in_dst_en), .wr_reg(in_dst), .wr_lat(lat),
    .rd_a(in_src0), .rd_b(in_src1), .rd_d(in_dst),
    .pend_a(pend_a), .pend_b(pend_b), .left_d(dst_left)
  );

  wb_slot_map #(.MAX_LAT(MAX_LAT)) u_wb (
    .clk(clk), .rst_n(rst_n),
    .claim(fire && in_dst_en), .lat(lat), .taken(slot_taken)
  );

  unit_busy_timer #(.II(DIV_II)) u_div (
    .clk(clk), .rst_n(rst_n), .start(fire && is_div), .busy(div_busy)
  );

  assign raw_hz = (in_src0_en && pend_a) || (in_src1_en && pend_b);
  assign waw_hz = in_dst_en && (lat < dst_left);
  assign wb_hz  = in_dst_en && slot_taken;
  assign div_hz = is_div && div_busy;
  assign hazard = raw_hz || waw_hz || wb_hz || div_hz;

  assign in_ready   = out_ready && !hazard;
  assign out_valid  = in_valid && !hazard;
  assign fire       = in_valid && in_ready;
  assign stall      = in_valid && hazard;
  assign out_class  = in_class;
  assign out_dst    = in_dst;
  assign out_dst_en = in_dst_en;

  // R1
  out_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid && !stall);

  // R3
  no_raw_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ((in_src0_en && pend_a) || (in_src1_en && pend_b)) |-> 1'b0);

  // R6
  div_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && is_div && DIV_II > 1 |=> !(fire && is_div));

  // R5
  waw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_dst_en |-> lat >= dst_left);
endmodule

// File: tb/issue_hazard_ctrl_bench.sv
`timescale 1ns/1ps
module issue_hazard_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_dst_en, in_src0_en, in_src1_en;
  logic [2:0] in_class, out_class;
  logic [4:0] in_dst, in_src0, in_src1, out_dst;
  logic       out_valid, out_ready, out_dst_en, stall;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  issue_hazard_ctrl u_issue_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_class(in_class),
    .in_dst(in_dst), .in_dst_en(in_dst_en),
    .in_src0(in_src0), .in_src0_en(in_src0_en),
    .in_src1(in_src1), .in_src1_en(in_src1_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
    .out_dst(out_dst), .out_dst_en(out_dst_en), .stall(stall)
  );

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Presents one instruction and returns the number of cycles it waited.
  task automatic send(input int cls, input int dst, input bit den,
                      input int s0, input bit s0en, input int s1, input bit s1en,
                      output int waited);
    waited = 0;
    @(negedge clk);
    in_valid = 1'b1; in_class = 3'(cls);
    in_dst = 5'(dst); in_dst_en = den;
    in_src0 = 5'(s0); in_src0_en = s0en;
    in_src1 = 5'(s1); in_src1_en = s1en;
    #1;
    while (!in_ready && waited < 200) begin
      @(negedge clk); #1;
      waited++;
    end
    chk("R1 out_valid on issue", int'(out_valid), 1);
    chk("R1 out_dst copy", int'(out_dst), dst);
    chk("R1 out_class copy", int'(out_class), cls);
  endtask

  task automatic t_reset();
    chk("R8 in_ready after reset", int'(in_ready), 1);
    chk("R1 out_valid idle", int'(out_valid), 0);
    chk("R9 stall idle", int'(stall), 0);
  endtask

  task automatic t_latency();
    int w;
    int cls_l [6] = '{0, 1, 2, 3, 4, 6};
    int lat_l [6] = '{0, 1, 3, 6, 24, 0};
    foreach (cls_l[i]) begin
      send(cls_l[i], 10, 1'b1, 0, 1'b0, 0, 1'b0, w);
      send(0, 0, 1'b0, 10, 1'b1, 0, 1'b0, w);
      chk($sformatf("R2 R3 consumer wait class %0d", cls_l[i]), w, lat_l[i]);
      idle(30);
    end
  endtask

  task automatic t_sources();
    int w;
    send(3, 3, 1'b1, 0, 1'b0, 0, 1'b0, w);
    send(0, 0, 1'b0, 4, 1'b1, 3, 1'b1, w);
    chk("R4 second source RAW", w, 6);
    idle(30);
    send(3, 3, 1'b1, 0, 1'b0, 0, 1'b0, w);
    send(0, 0, 1'b0, 4, 1'b1, 5, 1'b1, w);
    chk("R4 unrelated registers", w, 0);
    idle(30);
    send(3, 3, 1'b1, 0, 1'b0, 0, 1'b0, w);
    send(0, 0, 1'b0, 3, 1'b0, 3, 1'b0, w);
    chk("R4 disabled sources ignored", w, 0);
    idle(30);
  endtask

  task automatic t_waw();
    int w;
    send(3, 5, 1'b1, 0, 1'b0, 0, 1'b0, w);
    send(0, 5, 1'b1, 0, 1'b0, 0, 1'b0, w);
    chk("R5 ALU after multiply same dst", w, 6);
    idle(30);
    send(3, 5, 1'b1, 0, 1'b0, 0, 1'b0, w);
    send(1, 5, 1'b1, 0, 1'b0, 0, 1'b0, w);
    chk("R5 load after multiply same dst", w, 5);
    idle(30);
  endtask

  task automatic t_div();
    int w;
    send(4, 20, 1'b1, 0, 1'b0, 0, 1'b0, w);
    send(4, 21, 1'b1, 0, 1'b0, 0, 1'b0, w);
    chk("R6 divide after divide", w, 24);
    idle(30);
    send(4, 20, 1'b1, 0, 1'b0, 0, 1'b0, w);
    send(3, 22, 1'b1, 0, 1'b0, 0, 1'b0, w);
    chk("R6 multiply while divider busy", w, 0);
    idle(30);
  endtask

  task automatic t_wb();
    int w;
    send(1, 2, 1'b1, 0, 1'b0, 0, 1'b0, w);
    send(0, 3, 1'b1, 0, 1'b0, 0, 1'b0, w);
    chk("R7 writeback slot clash", w, 1);
    idle(30);
    send(1, 2, 1'b1, 0, 1'b0, 0, 1'b0, w);
    send(0, 3, 1'b0, 0, 1'b0, 0, 1'b0, w);
    chk("R7 no-destination op skips slot", w, 0);
    idle(30);
  endtask

  task automatic t_backpressure();
    int w;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_class = 3'd0; in_dst = 5'd1; in_dst_en = 1'b1;
    in_src0_en = 1'b0; in_src1_en = 1'b0;
    #1;
    chk("R1 in_ready low under back-pressure", int'(in_ready), 0);
    chk("R1 out_valid high without hazard", int'(out_valid), 1);
    chk("R9 no stall from back-pressure", int'(stall), 0);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b0;
    send(3, 6, 1'b1, 0, 1'b0, 0, 1'b0, w);
    @(negedge clk);
    in_valid = 1'b1; in_class = 3'd0; in_dst_en = 1'b0;
    in_src0 = 5'd6; in_src0_en = 1'b1; in_src1_en = 1'b0;
    #1;
    chk("R9 stall on hazard", int'(stall), 1);
    chk("R1 out_valid low on hazard", int'(out_valid), 0);
    idle(30);
  endtask

  task automatic t_reset_mid();
    int w;
    send(4, 12, 1'b1, 0, 1'b0, 0, 1'b0, w);
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    send(0, 0, 1'b0, 12, 1'b1, 0, 1'b0, w);
    chk("R8 register counters cleared", w, 0);
    send(4, 13, 1'b1, 0, 1'b0, 0, 1'b0, w);
    chk("R8 divider busy cleared", w, 0);
    idle(30);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_class = '0; in_dst = '0; in_dst_en = 1'b0;
    in_src0 = '0; in_src0_en = 1'b0; in_src1 = '0; in_src1_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_latency();
    t_sources();
    t_waw();
    t_div();
    t_wb();
    t_backpressure();
    t_reset_mid();
    summary();
  end
endmodule